// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm Interrupts

This block keeps a running count of days, hours, minutes and seconds. The count advances on a one-pulse-per-second strobe that an external prescaler supplies. A second set of registers, laid out the same way, holds an alarm time. The alarm event fires when the running time, after its update, matches all four alarm fields. Any pending event can be masked per bit, and the interrupt line is raised whenever a pending event is also enabled.

The alarm, the 1 Hz strobe, a stopwatch pulse and nine periodic tick inputs are collected in a 16-bit status register. Software clears a status bit by writing a 1 to it. This means that writing back a value just read clears exactly the events that were seen. All registers sit behind a simple 16-bit register port with a combinational read and a single-cycle write.

Top module: `tod_alarm_core`

## Requirements
- R1: After reset, every time, alarm, status and enable register reads 0 and irq_o is low.
- R2: Each cycle with tick_1hz_i high and no time-register write advances the seconds. The roll-overs are: seconds 59 to 0 with a carry into minutes, minutes 59 to 0 with a carry into hours, and hours 23 to 0 with a carry into days. Without a tick the time holds.
- R3: The day counter is DAY_W bits wide (16 by default, 9 as an option) and wraps from all ones to 0 on a carry.
- R4: The register offsets are: hour/minute 0x00, seconds 0x04, alarm hour/minute 0x08, alarm seconds 0x0C, status 0x14, enable 0x18, day 0x20, alarm day 0x24. In both hour/minute registers the hour sits in bits [15:8] and the minute in bits [7:0].
- R5: A write to the hour/minute, seconds or day register loads its value at that clock edge. A tick in the same cycle is dropped, so no field advances or carries.
- R6: Status bit 4 sets on every tick. Bit 0 sets when sw_evt_i is high. Bit 7+k sets when per_tick_i[k] is high.
- R7: Status bit 2 (alarm) sets on the tick whose updated day, hour, minute and second all equal the alarm registers. It does not set if any one of those fields differs. Once set, it stays set until cleared.
- R8: A write to the status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R9: When a hardware event and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R10: irq_o is high exactly when some bit of status AND enable is 1. With enable written to 0, irq_o stays low whatever the status is.
- R11: Reads from any other offset (such as 0x10 or 0x1C) return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_1hz_i | input | 1 | One-cycle seconds strobe from the prescaler |
| sw_evt_i | input | 1 | One-cycle stopwatch event |
| per_tick_i | input | 9 | Periodic tick events, bit k maps to status bit 7+k |
| addr_i | input | 6 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
Every write and every event input is registered once. Its effect on the registers and on the status bits is therefore due at the first rising edge after the input is driven. irq_o follows the registered status and enable combinationally, so it changes in that same cycle. The bench drives inputs on the falling edge and releases them one full cycle later. It reads back through the port a short delay after that second falling edge, which is after exactly one rising edge has passed. Simultaneous tick-and-write and set-and-clear cases are driven in one cycle so that the priority rule decides the outcome.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 6;
  localparam int SEC_W   = 6;
  localparam int MIN_W   = 6;
  localparam int HOUR_W  = 5;
  localparam int N_PER   = 9;
  localparam int STAT_W  = 16;

  localparam logic [ADDR_W-1:0] OFS_HM   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_SEC  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_AHM  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_ASEC = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_DAY  = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_ADAY = 6'h24;

  localparam int BIT_SW   = 0;
  localparam int BIT_ALM  = 2;
  localparam int BIT_HZ   = 4;
  localparam int BIT_PER0 = 7;

  localparam logic [STAT_W-1:0] STAT_IMPL =
    STAT_W'((1 << BIT_SW) | (1 << BIT_ALM) | (1 << BIT_HZ) |
            (((1 << N_PER) - 1) << BIT_PER0));
endpackage

// File: rtl/tod_time_chain.sv
module tod_time_chain
  import tod_pkg::*;
#(
  parameter int DAY_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              wr_sec_i,
  input  logic              wr_hm_i,
  input  logic              wr_day_i,
  input  logic [SEC_W-1:0]  wd_sec_i,
  input  logic [MIN_W-1:0]  wd_min_i,
  input  logic [HOUR_W-1:0] wd_hour_i,
  input  logic [DAY_W-1:0]  wd_day_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [MIN_W-1:0]  min_o,
  output logic [HOUR_W-1:0] hour_o,
  output logic [DAY_W-1:0]  day_o,
  output logic [SEC_W-1:0]  nxt_sec_o,
  output logic [MIN_W-1:0]  nxt_min_o,
  output logic [HOUR_W-1:0] nxt_hour_o,
  output logic [DAY_W-1:0]  nxt_day_o
);
  logic [SEC_W-1:0]  sec_q;
  logic [MIN_W-1:0]  min_q;
  logic [HOUR_W-1:0] hour_q;
  logic [DAY_W-1:0]  day_q;
  logic sec_wrap, min_wrap, hour_wrap;

  // >= keeps out-of-range software values from running away
  assign sec_wrap  = sec_q  >= SEC_W'(59);
  assign min_wrap  = min_q  >= MIN_W'(59);
  assign hour_wrap = hour_q >= HOUR_W'(23);

  always_comb begin
    nxt_sec_o  = sec_wrap ? '0 : sec_q + 1'b1;
    nxt_min_o  = min_q;
    nxt_hour_o = hour_q;
    nxt_day_o  = day_q;
    if (sec_wrap) begin
      nxt_min_o = min_wrap ? '0 : min_q + 1'b1;
      if (min_wrap) begin
        nxt_hour_o = hour_wrap ? '0 : hour_q + 1'b1;
        if (hour_wrap) nxt_day_o = day_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
      day_q  <= '0;
    end else if (adv_i) begin
      sec_q  <= nxt_sec_o;
      min_q  <= nxt_min_o;
      hour_q <= nxt_hour_o;
      day_q  <= nxt_day_o;
    end else begin
      if (wr_sec_i) sec_q <= wd_sec_i;
      if (wr_hm_i) begin
        min_q  <= wd_min_i;
        hour_q <= wd_hour_i;
      end
      if (wr_day_i) day_q <= wd_day_i;
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;
  assign day_o  = day_q;
endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
  import tod_pkg::*;
#(
  parameter int DAY_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_sec_i,
  input  logic              wr_hm_i,
  input  logic              wr_day_i,
  input  logic [SEC_W-1:0]  wd_sec_i,
  input  logic [MIN_W-1:0]  wd_min_i,
  input  logic [HOUR_W-1:0] wd_hour_i,
  input  logic [DAY_W-1:0]  wd_day_i,
  input  logic              adv_i,
  input  logic [SEC_W-1:0]  nxt_sec_i,
  input  logic [MIN_W-1:0]  nxt_min_i,
  input  logic [HOUR_W-1:0] nxt_hour_i,
  input  logic [DAY_W-1:0]  nxt_day_i,
  output logic [SEC_W-1:0]  al_sec_o,
  output logic [MIN_W-1:0]  al_min_o,
  output logic [HOUR_W-1:0] al_hour_o,
  output logic [DAY_W-1:0]  al_day_o,
  output logic              hit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      al_sec_o  <= '0;
      al_min_o  <= '0;
      al_hour_o <= '0;
      al_day_o  <= '0;
    end else begin
      if (wr_sec_i) al_sec_o <= wd_sec_i;
      if (wr_hm_i) begin
        al_min_o  <= wd_min_i;
        al_hour_o <= wd_hour_i;
      end
      if (wr_day_i) al_day_o <= wd_day_i;
    end
  end

  // compared against the value the counter is about to load
  assign hit_o = adv_i && (nxt_sec_i == al_sec_o) && (nxt_min_i == al_min_o) &&
                 (nxt_hour_i == al_hour_o) && (nxt_day_i == al_day_o);
endmodule

// File: rtl/tod_irq_unit.sv
module tod_irq_unit
  import tod_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] set_i,
  input  logic [STAT_W-1:0] clr_i,
  input  logic              wr_ien_i,
  input  logic [STAT_W-1:0] wd_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] ien_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] stat_q, ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      ien_q  <= '0;
    end else begin
      stat_q <= ((stat_q & ~clr_i) | set_i) & STAT_IMPL;
      if (wr_ien_i) ien_q <= wd_i;
    end
  end

  assign stat_o = stat_q;
  assign ien_o  = ien_q;
  assign irq_o  = |(stat_q & ien_q);
endmodule

// File: rtl/tod_alarm_core.sv
module tod_alarm_core
  import tod_pkg::*;
#(
  parameter int DAY_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_1hz_i,
  input  logic              sw_evt_i,
  input  logic [N_PER-1:0]  per_tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic wr_hm, wr_sec, wr_day, wr_ahm, wr_asec, wr_aday, wr_stat, wr_ien;
  logic time_wr, adv, alarm_hit;
  logic [SEC_W-1:0]  wd_sec, sec_w, nxt_sec, al_sec;
  logic [MIN_W-1:0]  wd_min, min_w, nxt_min, al_min;
  logic [HOUR_W-1:0] wd_hour, hour_w, nxt_hour, al_hour;
  logic [DAY_W-1:0]  wd_day, day_w, nxt_day, al_day;
  logic [STAT_W-1:0] set_vec, clr_vec, stat_w, ien_w;

  assign wr_hm   = wr_en_i && (addr_i == OFS_HM);
  assign wr_sec  = wr_en_i && (addr_i == OFS_SEC);
  assign wr_day  = wr_en_i && (addr_i == OFS_DAY);
  assign wr_ahm  = wr_en_i && (addr_i == OFS_AHM);
  assign wr_asec = wr_en_i && (addr_i == OFS_ASEC);
  assign wr_aday = wr_en_i && (addr_i == OFS_ADAY);
  assign wr_stat = wr_en_i && (addr_i == OFS_STAT);
  assign wr_ien  = wr_en_i && (addr_i == OFS_IEN);

  assign wd_sec  = wdata_i[SEC_W-1:0];
  assign wd_min  = wdata_i[MIN_W-1:0];
  assign wd_hour = wdata_i[8 +: HOUR_W];
  assign wd_day  = wdata_i[DAY_W-1:0];

  assign time_wr = wr_hm || wr_sec || wr_day;
  assign adv     = tick_1hz_i && !time_wr;

  tod_time_chain #(.DAY_W(DAY_W)) u_time (
    .clk_i, .rst_ni, .adv_i(adv),
    .wr_sec_i(wr_sec), .wr_hm_i(wr_hm), .wr_day_i(wr_day),
    .wd_sec_i(wd_sec), .wd_min_i(wd_min), .wd_hour_i(wd_hour), .wd_day_i(wd_day),
    .sec_o(sec_w), .min_o(min_w), .hour_o(hour_w), .day_o(day_w),
    .nxt_sec_o(nxt_sec), .nxt_min_o(nxt_min), .nxt_hour_o(nxt_hour), .nxt_day_o(nxt_day)
  );

  tod_alarm_unit #(.DAY_W(DAY_W)) u_alarm (
    .clk_i, .rst_ni,
    .wr_sec_i(wr_asec), .wr_hm_i(wr_ahm), .wr_day_i(wr_aday),
    .wd_sec_i(wd_sec), .wd_min_i(wd_min), .wd_hour_i(wd_hour), .wd_day_i(wd_day),
    .adv_i(adv), .nxt_sec_i(nxt_sec), .nxt_min_i(nxt_min),
    .nxt_hour_i(nxt_hour), .nxt_day_i(nxt_day),
    .al_sec_o(al_sec), .al_min_o(al_min), .al_hour_o(al_hour), .al_day_o(al_day),
    .hit_o(alarm_hit)
  );

  always_comb begin
    set_vec = '0;
    set_vec[BIT_SW]  = sw_evt_i;
    set_vec[BIT_ALM] = alarm_hit;
    set_vec[BIT_HZ]  = tick_1hz_i;
    set_vec[BIT_PER0 +: N_PER] = per_tick_i;
  end

  assign clr_vec = wr_stat ? wdata_i : '0;

  tod_irq_unit u_irq (
    .clk_i, .rst_ni, .set_i(set_vec), .clr_i(clr_vec),
    .wr_ien_i(wr_ien), .wd_i(wdata_i),
    .stat_o(stat_w), .ien_o(ien_w), .irq_o(irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_HM:   rdata_o = {8'(hour_w), 8'(min_w)};
      OFS_SEC:  rdata_o = DATA_W'(sec_w);
      OFS_AHM:  rdata_o = {8'(al_hour), 8'(al_min)};
      OFS_ASEC: rdata_o = DATA_W'(al_sec);
      OFS_STAT: rdata_o = stat_w;
      OFS_IEN:  rdata_o = ien_w;
      OFS_DAY:  rdata_o = DATA_W'(day_w);
      OFS_ADAY: rdata_o = DATA_W'(al_day);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tod_alarm_core_chk.sv
module tod_alarm_core_chk
  import tod_pkg::*;
#(
  parameter int DAY_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_1hz_i,
  input logic              time_wr,
  input logic              adv,
  input logic [SEC_W-1:0]  sec_w,
  input logic [MIN_W-1:0]  min_w,
  input logic [HOUR_W-1:0] hour_w,
  input logic [DAY_W-1:0]  day_w,
  input logic [STAT_W-1:0] stat_w,
  input logic [STAT_W-1:0] ien_w,
  input logic [STAT_W-1:0] set_vec,
  input logic [STAT_W-1:0] clr_vec,
  input logic              irq_o
);
  a_r2_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && sec_w == SEC_W'(59)) |=> (sec_w == '0));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_1hz_i && !time_wr) |=> ($stable(sec_w) && $stable(min_w) &&
                                   $stable(hour_w) && $stable(day_w)));

  a_r3_day_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && day_w == '1 && hour_w == HOUR_W'(23) && min_w == MIN_W'(59) &&
     sec_w == SEC_W'(59)) |=> (day_w == '0));

  a_r5_no_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_1hz_i && time_wr) |-> !adv);

  a_r6_hz_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_1hz_i |=> stat_w[BIT_HZ]);

  a_r7_alarm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_w[BIT_ALM] && !clr_vec[BIT_ALM]) |=> stat_w[BIT_ALM]);

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_vec[BIT_HZ] && !set_vec[BIT_HZ]) |=> !stat_w[BIT_HZ]);

  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vec[BIT_HZ] && clr_vec[BIT_HZ]) |=> stat_w[BIT_HZ]);

  a_r10_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_w == '0) |-> !irq_o);

  a_r10_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((stat_w & ien_w) != '0));
endmodule

bind tod_alarm_core tod_alarm_core_chk #(.DAY_W(DAY_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_1hz_i(tick_1hz_i),
  .time_wr(time_wr), .adv(adv),
  .sec_w(sec_w), .min_w(min_w), .hour_w(hour_w), .day_w(day_w),
  .stat_w(stat_w), .ien_w(ien_w), .set_vec(set_vec), .clr_vec(clr_vec),
  .irq_o(irq_o)
);

// File: tb/tod_alarm_core_test.sv
`timescale 1ns/1ps
module tod_alarm_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        sw = 1'b0;
  logic [8:0]  per = '0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tod_alarm_core uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_1hz_i(tick), .sw_evt_i(sw),
    .per_tick_i(per), .addr_i(addr), .wr_en_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  // start {day,hour,min,sec} -> expected after one tick
  localparam logic [79:0] VEC [7] = '{
    {16'd0,     8'd0,  8'd0,  8'd0,  16'd0, 8'd0,  8'd0,  8'd1},
    {16'd0,     8'd0,  8'd0,  8'd59, 16'd0, 8'd0,  8'd1,  8'd0},
    {16'd0,     8'd0,  8'd59, 8'd59, 16'd0, 8'd1,  8'd0,  8'd0},
    {16'd0,     8'd23, 8'd59, 8'd59, 16'd1, 8'd0,  8'd0,  8'd0},
    {16'd5,     8'd12, 8'd30, 8'd20, 16'd5, 8'd12, 8'd30, 8'd21},
    {16'd7,     8'd10, 8'd59, 8'd30, 16'd7, 8'd10, 8'd59, 8'd31},
    {16'hFFFF,  8'd23, 8'd59, 8'd59, 16'd0, 8'd0,  8'd0,  8'd0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [5:0] a, input logic [15:0] d,
                      input logic tk, input logic s, input logic [8:0] p);
    @(negedge clk);
    we = w; addr = a; wdata = d; tick = tk; sw = s; per = p;
    @(negedge clk);
    we = 1'b0; tick = 1'b0; sw = 1'b0; per = '0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, 9'd0);
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic set_time(input logic [15:0] dy, input logic [7:0] hr,
                          input logic [7:0] mn, input logic [7:0] sc);
    wr(6'h20, dy);
    wr(6'h00, {hr, mn});
    wr(6'h04, {8'd0, sc});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    foreach (VEC[i]) begin end
    rd(6'h00, v); chk("R1 hm", v, 16'h0);
    rd(6'h04, v); chk("R1 sec", v, 16'h0);
    rd(6'h20, v); chk("R1 day", v, 16'h0);
    rd(6'h08, v); chk("R1 alarm hm", v, 16'h0);
    rd(6'h14, v); chk("R1 status", v, 16'h0);
    rd(6'h18, v); chk("R1 enable", v, 16'h0);
    chk("R1 irq", {15'd0, irq}, 16'h0);

    // R2 R3 R4 roll-over vectors
    for (int i = 0; i < 7; i++) begin
      set_time(VEC[i][79:64], VEC[i][63:56], VEC[i][55:48], VEC[i][47:40]);
      step(1'b0, 6'h00, 16'h0, 1'b1, 1'b0, 9'd0);
      rd(6'h20, v); chk("R2/R3 day", v, VEC[i][39:24]);
      rd(6'h00, v); chk("R2/R4 hour/min", v, VEC[i][23:8]);
      rd(6'h04, v); chk("R2 sec", v, {8'd0, VEC[i][7:0]});
    end

    // R2 no tick holds
    step(1'b0, 6'h00, 16'h0, 1'b0, 1'b0, 9'd0);
    rd(6'h04, v); chk("R2 hold sec", v, 16'h0);

    // R7 alarm match, R10 interrupt
    wr(6'h14, 16'hFFFF);
    wr(6'h18, 16'h0004);
    wr(6'h24, 16'd3);
    wr(6'h08, 16'h0405);
    wr(6'h0C, 16'd6);
    rd(6'h08, v); chk("R4 alarm hm", v, 16'h0405);
    set_time(16'd3, 8'd4, 8'd5, 8'd5);
    chk("R10 irq idle", {15'd0, irq}, 16'h0);
    step(1'b0, 6'h00, 16'h0, 1'b1, 1'b0, 9'd0);
    rd(6'h14, v); chk("R7 alarm set", v, 16'h0014);
    chk("R10 irq on", {15'd0, irq}, 16'h1);
    step(1'b0, 6'h00, 16'h0, 1'b1, 1'b0, 9'd0);
    rd(6'h14, v); chk("R7 alarm sticky", v, 16'h0014);

    // R8 write-one-to-clear
    wr(6'h14, 16'h0010);
    rd(6'h14, v); chk("R8 partial clear", v, 16'h0004);
    chk("R10 irq held", {15'd0, irq}, 16'h1);
    wr(6'h14, 16'h0004);
    rd(6'h14, v); chk("R8 full clear", v, 16'h0000);
    chk("R10 irq off", {15'd0, irq}, 16'h0);

    // R7 day mismatch
    set_time(16'd2, 8'd4, 8'd5, 8'd5);
    step(1'b0, 6'h00, 16'h0, 1'b1, 1'b0, 9'd0);
    rd(6'h14, v); chk("R7 no match", v, 16'h0010);

    // R9 set beats clear
    step(1'b1, 6'h14, 16'h0010, 1'b1, 1'b0, 9'd0);
    rd(6'h14, v); chk("R9 set wins", v, 16'h0010);

    // R5 write drops tick
    step(1'b1, 6'h04, 16'd59, 1'b1, 1'b0, 9'd0);
    rd(6'h04, v); chk("R5 sec loaded", v, 16'd59);
    rd(6'h00, v); chk("R5 no carry", v, 16'h0405);
    step(1'b0, 6'h00, 16'h0, 1'b1, 1'b0, 9'd0);
    rd(6'h04, v); chk("R2 sec wrap", v, 16'd0);
    rd(6'h00, v); chk("R2 min carry", v, 16'h0406);

    // R6 event sources
    wr(6'h14, 16'hFFFF);
    step(1'b0, 6'h00, 16'h0, 1'b0, 1'b1, 9'd0);
    rd(6'h14, v); chk("R6 stopwatch", v, 16'h0001);
    step(1'b0, 6'h00, 16'h0, 1'b0, 1'b0, 9'h100);
    rd(6'h14, v); chk("R6 periodic top", v, 16'h8001);
    step(1'b0, 6'h00, 16'h0, 1'b0, 1'b0, 9'h001);
    rd(6'h14, v); chk("R6 periodic low", v, 16'h8081);

    // R10 masking
    wr(6'h18, 16'hFFFF);
    rd(6'h18, v); chk("R4 enable rb", v, 16'hFFFF);
    chk("R10 irq enabled", {15'd0, irq}, 16'h1);
    wr(6'h18, 16'h0000);
    chk("R10 irq masked", {15'd0, irq}, 16'h0);

    // R11 unused offsets
    wr(6'h1C, 16'h1234);
    rd(6'h1C, v); chk("R11 read 1C", v, 16'h0);
    rd(6'h10, v); chk("R11 read 10", v, 16'h0);
    rd(6'h00, v); chk("R11 hm intact", v, 16'h0406);
    rd(6'h14, v); chk("R11 status intact", v, 16'h8081);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule